// File: doc/BRIEF.md
# Paired Mealy and Moore State Machines

This block holds two small synchronous state machines that run side by side on one clock, one synchronous reset and one serial input bit. One machine is of the Mealy kind: its output symbol is decoded from its current state together with the input bit present in the same cycle. The other is of the Moore kind: its output symbol is decoded from its current state alone. Each machine has four states, named a, b, c and d, and follows its own fixed transition table.

Both machines report their output as a 2-bit symbol code standing for x1, x2 or x3. Both also expose their current state so that the two can be compared directly. Because the two machines share the same input stream, the one-cycle gap in output reaction between the two styles is visible at the ports. The Mealy symbol moves as soon as the input moves. The Moore symbol moves only after a rising edge has loaded a new state.

Top module: `dual_fsm_top`

## Requirements
- R1: A rising clock edge with `rst` high places both machines in state a, whatever `din` holds. After such an edge, `moore_sym` reads x2 and `mealy_sym` reads x1.
- R2: State codes are a=2'b00, b=2'b01, c=2'b10 and d=2'b11. Symbol codes are x1=2'b01, x2=2'b10 and x3=2'b11. Neither symbol output ever shows 2'b00 outside reset.
- R3: From state a, the Mealy machine outputs x1 on either input. It moves to b when `din`=0 and to c when `din`=1.
- R4: From state b, the Mealy machine outputs x2 and stays in b when `din`=0. It outputs x3 and moves to d when `din`=1.
- R5: From state c, the Mealy machine outputs x3 and moves to d when `din`=0. It outputs x1 and stays in c when `din`=1.
- R6: In state d, the Mealy machine stays in d. It outputs x3 when `din`=0 and x2 when `din`=1.
- R7: The Moore machine moves as follows. State a goes to b on 0 and to c on 1. State b stays in b on 0 and goes to d on 1. State c stays in c on 0 and goes to d on 1. State d stays in d on either input.
- R8: The Moore symbol depends on state only: a gives x2, b gives x1, c gives x2 and d gives x3.
- R9: A change of `din` inside a cycle changes `mealy_sym` in that same cycle, with no clock edge needed. `moore_sym` and both state outputs hold until the next rising edge.
- R10: States change only on rising clock edges. With `rst` low, each edge applies exactly one table step using the `din` value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit shared by both machines |
| mealy_sym | output | 2 | Mealy output symbol, decoded from state and `din` |
| moore_sym | output | 2 | Moore output symbol, decoded from state only |
| mealy_state | output | 2 | Current Mealy state code |
| moore_state | output | 2 | Current Moore state code |

## Verification
Both state outputs and `moore_sym` are due one rising edge after the `din` value they depend on. `mealy_sym` is due in the same cycle, as soon as `din` settles. The bench changes `din` at the falling edge and samples all outputs one time unit later. It compares them against model states that are advanced only at the rising edge, so every output is checked in the cycle where it is due. For R9, `din` is flipped twice within one low clock phase. `mealy_sym` must follow each flip while the Moore side stays unchanged.

// File: rtl/dual_fsm_pkg.sv
package dual_fsm_pkg;

    localparam int STATE_W = 2;
    localparam int SYM_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 2'b00,
        ST_B = 2'b01,
        ST_C = 2'b10,
        ST_D = 2'b11
    } fsm_state_t;

    typedef enum logic [SYM_W-1:0] {
        SYM_NONE = 2'b00,
        SYM_X1   = 2'b01,
        SYM_X2   = 2'b10,
        SYM_X3   = 2'b11
    } fsm_sym_t;

    typedef struct packed {
        fsm_state_t st;
    } mealy_regs_t;

    typedef struct packed {
        fsm_state_t st;
    } moore_regs_t;

endpackage

// File: rtl/mealy_fsm.sv
module mealy_fsm
    import dual_fsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic [STATE_W-1:0] state_o,
    output logic [SYM_W-1:0]   sym_o
);

    mealy_regs_t regs_q;
    mealy_regs_t regs_d;
    fsm_sym_t    sym_d;

    // next state and same-cycle output from state plus input
    always_comb begin
        regs_d = regs_q;
        sym_d  = SYM_X1;
        unique case (regs_q.st)
            ST_A: begin
                sym_d     = SYM_X1;
                regs_d.st = din ? ST_C : ST_B;
            end
            ST_B: begin
                sym_d     = din ? SYM_X3 : SYM_X2;
                regs_d.st = din ? ST_D : ST_B;
            end
            ST_C: begin
                sym_d     = din ? SYM_X1 : SYM_X3;
                regs_d.st = din ? ST_C : ST_D;
            end
            ST_D: begin
                sym_d     = din ? SYM_X2 : SYM_X3;
                regs_d.st = ST_D;
            end
            default: begin
                sym_d     = SYM_X1;
                regs_d.st = ST_A;
            end
        endcase
        if (rst) begin
            regs_d.st = ST_A;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.st;
    assign sym_o   = sym_d;

endmodule

// File: rtl/moore_fsm.sv
module moore_fsm
    import dual_fsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic [STATE_W-1:0] state_o,
    output logic [SYM_W-1:0]   sym_o
);

    moore_regs_t regs_q;
    moore_regs_t regs_d;
    fsm_sym_t    sym_dec;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_A:    regs_d.st = din ? ST_C : ST_B;
            ST_B:    regs_d.st = din ? ST_D : ST_B;
            ST_C:    regs_d.st = din ? ST_D : ST_C;
            ST_D:    regs_d.st = ST_D;
            default: regs_d.st = ST_A;
        endcase
        if (rst) begin
            regs_d.st = ST_A;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // output decoded from the registered state only
    always_comb begin
        unique case (regs_q.st)
            ST_A:    sym_dec = SYM_X2;
            ST_B:    sym_dec = SYM_X1;
            ST_C:    sym_dec = SYM_X2;
            ST_D:    sym_dec = SYM_X3;
            default: sym_dec = SYM_X2;
        endcase
    end

    assign state_o = regs_q.st;
    assign sym_o   = sym_dec;

endmodule

// File: rtl/dual_fsm_top.sv
module dual_fsm_top
    import dual_fsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    output logic [SYM_W-1:0]   mealy_sym,
    output logic [SYM_W-1:0]   moore_sym,
    output logic [STATE_W-1:0] mealy_state,
    output logic [STATE_W-1:0] moore_state
);

    mealy_fsm u_mealy (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .state_o (mealy_state),
        .sym_o   (mealy_sym)
    );

    moore_fsm u_moore (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .state_o (moore_state),
        .sym_o   (moore_sym)
    );

endmodule

// File: rtl/dual_fsm_checker.sv
module dual_fsm_checker
    import dual_fsm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               din,
    input logic [SYM_W-1:0]   mealy_sym,
    input logic [SYM_W-1:0]   moore_sym,
    input logic [STATE_W-1:0] mealy_state,
    input logic [STATE_W-1:0] moore_state
);

    logic seen_rst_q;
    always_ff @(posedge clk) begin
        if (rst) seen_rst_q <= 1'b1;
        else if (seen_rst_q !== 1'b1) seen_rst_q <= 1'b0;
    end

    assert_reset_to_a_R1: assert property (@(posedge clk)
        rst |=> (mealy_state == 2'b00 && moore_state == 2'b00));

    assert_no_null_sym_R2: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (mealy_sym != 2'b00 && moore_sym != 2'b00));

    assert_mealy_a_out_R3: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (mealy_state == 2'b00) |-> (mealy_sym == 2'b01));

    assert_mealy_b_step_R4: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (mealy_state == 2'b01 && din) |=> (mealy_state == 2'b11));

    assert_mealy_c_hold_R5: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (mealy_state == 2'b10 && din) |=> (mealy_state == 2'b10));

    assert_mealy_d_sink_R6: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (mealy_state == 2'b11) |=> (mealy_state == 2'b11));

    assert_moore_d_sink_R7: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        (moore_state == 2'b11) |=> (moore_state == 2'b11));

    assert_moore_state_only_R8: assert property (@(posedge clk) disable iff (rst || seen_rst_q !== 1'b1)
        $stable(moore_state) |-> $stable(moore_sym));

endmodule

bind dual_fsm_top dual_fsm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .mealy_sym   (mealy_sym),
    .moore_sym   (moore_sym),
    .mealy_state (mealy_state),
    .moore_state (moore_state)
);

// File: tb/tb_dual_fsm_top.sv
module tb_dual_fsm_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [1:0] mealy_sym, moore_sym, mealy_state, moore_state;

    int n_vec  = 0;
    int n_fail = 0;
    logic [1:0] m_ly = 2'b00;
    logic [1:0] m_re = 2'b00;

    always #4 clk = ~clk;

    dual_fsm_top dut (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .mealy_sym   (mealy_sym),
        .moore_sym   (moore_sym),
        .mealy_state (mealy_state),
        .moore_state (moore_state)
    );

    // reference model: states a=0 b=1 c=2 d=3, x1=1 x2=2 x3=3
    function automatic logic [1:0] ly_next(logic [1:0] s, logic d);
        case (s)
            2'd0: return d ? 2'd2 : 2'd1;
            2'd1: return d ? 2'd3 : 2'd1;
            2'd2: return d ? 2'd2 : 2'd3;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] ly_out(logic [1:0] s, logic d);
        case (s)
            2'd0: return 2'd1;
            2'd1: return d ? 2'd3 : 2'd2;
            2'd2: return d ? 2'd1 : 2'd3;
            default: return d ? 2'd2 : 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] re_next(logic [1:0] s, logic d);
        case (s)
            2'd0: return d ? 2'd2 : 2'd1;
            2'd1: return d ? 2'd3 : 2'd1;
            2'd2: return d ? 2'd3 : 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] re_out(logic [1:0] s);
        case (s)
            2'd0: return 2'd2;
            2'd1: return 2'd1;
            2'd2: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic string ly_tag(logic [1:0] s);
        case (s)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, check after settling, clock it, advance model
    task automatic step(logic d, logic r);
        @(negedge clk);
        din = d;
        rst = r;
        #1;
        chk("R10", "mealy_state", mealy_state, m_ly);
        chk("R7",  "moore_state", moore_state, m_re);
        chk(ly_tag(m_ly), "mealy_sym", mealy_sym, ly_out(m_ly, d));
        chk("R8",  "moore_sym", moore_sym, re_out(m_re));
        if (mealy_sym == 2'b00 || moore_sym == 2'b00)
            chk("R2", "null symbol", 2'b00, 2'b01);
        @(posedge clk);
        if (r) begin
            m_ly = 2'd0;
            m_re = 2'd0;
        end else begin
            m_ly = ly_next(m_ly, d);
            m_re = re_next(m_re, d);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(posedge clk);
        @(posedge clk);
        // R1: reset state, with din high during reset
        @(negedge clk);
        din = 1'b1;
        #1;
        chk("R1", "mealy_state", mealy_state, 2'b00);
        chk("R1", "moore_state", moore_state, 2'b00);
        chk("R1", "moore_sym", moore_sym, 2'b10);
        chk("R1", "mealy_sym", mealy_sym, 2'b01);

        // directed paths through every table row
        step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
        step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b1);

        // R9: go to b, then flip din twice inside one low phase
        step(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        din = 1'b0;
        #1;
        chk("R9", "mealy_sym din=0", mealy_sym, 2'b10);
        chk("R9", "moore_sym", moore_sym, 2'b01);
        din = 1'b1;
        #1;
        chk("R9", "mealy_sym din=1", mealy_sym, 2'b11);
        chk("R9", "moore_sym held", moore_sym, 2'b01);
        chk("R9", "mealy_state held", mealy_state, 2'b01);
        chk("R9", "moore_state held", moore_state, 2'b01);
        @(posedge clk);
        m_ly = ly_next(m_ly, 1'b1);
        m_re = re_next(m_re, 1'b1);

        // random stimulus with occasional reset
        for (int i = 0; i < 3000; i++) begin
            logic rr;
            rr = ($urandom % 16) == 0;
            step(1'($urandom % 2), rr);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule